// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block holds the refresh row counter of a small 8-bit processor core and forms the address that is put on the 16-bit bus during the refresh slot of each opcode fetch. Each time the fetch sequencer reports a finished opcode fetch, the block raises a refresh strobe for one cycle. It drives an address made of the interrupt page register in the high byte and the refresh counter in the low byte. The low seven counter bits then step by one. The most significant counter bit only changes when software writes the counter directly.

Software can write the counter and the page register through two separate load ports. A write to the counter sets the point from which counting continues. Both registers are visible on output ports so that their state can be observed.

There is no valid/ready handshake. The refresh slot is fixed by the fetch timing and cannot be stalled, so no back-pressure exists: the consumer must accept every strobe in the cycle it appears. All other pins are plain control and data.

Top module: `refresh_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the page register, the strobe and the refresh address all become zero after that edge.
- R2: When `fetch_done` is high and `r_load` is low at an edge, counter bits 6:0 increase by one after that edge.
- R3: An increment never changes counter bit 7. Only a load changes bit 7.
- R4: Counter bits 6:0 wrap from 0x7F to 0x00 with no carry into bit 7.
- R5: When `r_load` is high at an edge, the counter takes all 8 bits of `r_wdata`. Later increments start from that value.
- R6: If `r_load` and `fetch_done` are both high at the same edge, the load wins and no increment is applied. The refresh slot for that fetch still occurs.
- R7: When `i_load` is high at an edge, the page register takes `i_wdata`. The counter is not affected by `i_load`.
- R8: In the cycle after an edge with `fetch_done` high, `rfsh_strobe` is high for exactly one cycle. During that cycle `rfsh_addr[15:8]` is the page register value and `rfsh_addr[7:0]` is the counter value, both as they stood before that edge.
- R9: Whenever `rfsh_strobe` is low, `rfsh_addr` is 0x0000.
- R10: With `fetch_done`, `r_load` and `rst` all low, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_done | input | 1 | One-cycle pulse: an opcode fetch has completed |
| r_load | input | 1 | Write enable for the refresh counter |
| r_wdata | input | 8 | Data written to the refresh counter |
| i_load | input | 1 | Write enable for the page register |
| i_wdata | input | 8 | Data written to the page register |
| rfsh_strobe | output | 1 | Refresh control, high during the refresh slot |
| rfsh_addr | output | 16 | Refresh address, {page, counter}; zero outside the slot |
| r_value | output | 8 | Current refresh counter |
| i_value | output | 8 | Current page register |

## Verification
The bound checker checks these rules on every cycle:
- the counter step and the hold of bit 7 across increments;
- load priority over a fetch in the same cycle, and the page register write;
- counter stability while idle;
- the strobe following each fetch pulse by one cycle;
- a zero address outside the slot.

Only the bench scenarios can show some results:
- the exact refresh address formed from the register values before the edge;
- the 0x7F to 0x00 wrap with bit 7 set and with bit 7 clear;
- counting resuming from a loaded start point;
- reset taking effect in the middle of activity.

The bench compares these against its own model on every clock.

// File: rtl/refgen_pkg.sv
package refgen_pkg;
  // Default register width and number of top counter bits that never step
  localparam int unsigned RG_DATA_W    = 8;
  localparam int unsigned RG_HELD_BITS = 1;

  // Next-value source of the refresh counter, in priority order
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_STEP = 2'd1,
    SRC_LOAD = 2'd2
  } row_src_e;
endpackage

// File: rtl/rg_row_counter.sv
module rg_row_counter
  import refgen_pkg::*;
#(
  parameter int unsigned W         = RG_DATA_W,
  parameter int unsigned HELD_BITS = RG_HELD_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  localparam int unsigned CNT_W = W - HELD_BITS;

  row_src_e             src;
  logic [CNT_W-1:0]     low_q;

  always_comb begin
    if (load)      src = SRC_LOAD;
    else if (step) src = SRC_STEP;
    else           src = SRC_HOLD;
  end

  // Counting section: wraps inside its own width, no carry out
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
    end else begin
      case (src)
        SRC_LOAD: low_q <= wdata[CNT_W-1:0];
        SRC_STEP: low_q <= low_q + CNT_W'(1);
        default:  low_q <= low_q;
      endcase
    end
  end

  generate
    if (HELD_BITS > 0) begin : g_held
      logic [W-1:CNT_W] top_q;
      // Held section: written only by an explicit load
      always_ff @(posedge clk) begin
        if (rst)                 top_q <= '0;
        else if (src == SRC_LOAD) top_q <= wdata[W-1:CNT_W];
      end
      assign value = {top_q, low_q};
    end else begin : g_full
      assign value = low_q;
    end
  endgenerate
endmodule

// File: rtl/rg_page_reg.sv
module rg_page_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (load) value <= wdata;
  end
endmodule

// File: rtl/rg_slot_driver.sv
module rg_slot_driver #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fetch,
  input  logic [W-1:0]   page,
  input  logic [W-1:0]   row,
  output logic           strobe,
  output logic [2*W-1:0] addr
);
  // One slot per fetch; the address is zero whenever no slot is active
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= 1'b0;
      addr   <= '0;
    end else begin
      strobe <= fetch;
      addr   <= fetch ? {page, row} : '0;
    end
  end
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen
  import refgen_pkg::*;
#(
  parameter int unsigned DATA_W    = RG_DATA_W,
  parameter int unsigned HELD_BITS = RG_HELD_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fetch_done,
  input  logic                  r_load,
  input  logic [DATA_W-1:0]     r_wdata,
  input  logic                  i_load,
  input  logic [DATA_W-1:0]     i_wdata,
  output logic                  rfsh_strobe,
  output logic [2*DATA_W-1:0]   rfsh_addr,
  output logic [DATA_W-1:0]     r_value,
  output logic [DATA_W-1:0]     i_value
);
  rg_row_counter #(.W(DATA_W), .HELD_BITS(HELD_BITS)) u_row (
    .clk   (clk),
    .rst   (rst),
    .step  (fetch_done),
    .load  (r_load),
    .wdata (r_wdata),
    .value (r_value)
  );

  rg_page_reg #(.W(DATA_W)) u_page (
    .clk   (clk),
    .rst   (rst),
    .load  (i_load),
    .wdata (i_wdata),
    .value (i_value)
  );

  rg_slot_driver #(.W(DATA_W)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .fetch  (fetch_done),
    .page   (i_value),
    .row    (r_value),
    .strobe (rfsh_strobe),
    .addr   (rfsh_addr)
  );
endmodule

// File: rtl/refresh_addr_gen_checker.sv
module refresh_addr_gen_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HELD_BITS = 1
) (
  input logic                clk,
  input logic                rst,
  input logic                fetch_done,
  input logic                r_load,
  input logic [DATA_W-1:0]   r_wdata,
  input logic                i_load,
  input logic [DATA_W-1:0]   i_wdata,
  input logic                rfsh_strobe,
  input logic [2*DATA_W-1:0] rfsh_addr,
  input logic [DATA_W-1:0]   r_value,
  input logic [DATA_W-1:0]   i_value
);
  localparam int unsigned CNT_W = DATA_W - HELD_BITS;

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (fetch_done && !r_load) |=> (r_value[CNT_W-1:0] == CNT_W'($past(r_value[CNT_W-1:0]) + 1'b1))); // R2

  AST_TOP_HELD: assert property (@(posedge clk) disable iff (rst)
    !r_load |=> (r_value[DATA_W-1:CNT_W] == $past(r_value[DATA_W-1:CNT_W]))); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    r_load |=> (r_value == $past(r_wdata))); // R6

  AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (rst)
    i_load |=> (i_value == $past(i_wdata))); // R7

  AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> rfsh_strobe); // R8

  AST_NO_SPARE_SLOT: assert property (@(posedge clk) disable iff (rst)
    !fetch_done |=> !rfsh_strobe); // R8

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rfsh_strobe |-> (rfsh_addr == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fetch_done && !r_load) |=> $stable(r_value)); // R10
endmodule

bind refresh_addr_gen refresh_addr_gen_checker #(.DATA_W(DATA_W), .HELD_BITS(HELD_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_done  (fetch_done),
  .r_load      (r_load),
  .r_wdata     (r_wdata),
  .i_load      (i_load),
  .i_wdata     (i_wdata),
  .rfsh_strobe (rfsh_strobe),
  .rfsh_addr   (rfsh_addr),
  .r_value     (r_value),
  .i_value     (i_value)
);

// File: tb/test_refresh_addr_gen.sv
module test_refresh_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_done = 1'b0;
  logic        r_load = 1'b0;
  logic [7:0]  r_wdata = '0;
  logic        i_load = 1'b0;
  logic [7:0]  i_wdata = '0;
  logic        rfsh_strobe;
  logic [15:0] rfsh_addr;
  logic [7:0]  r_value;
  logic [7:0]  i_value;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // Behavioural reference state
  int m_r = 0, m_i = 0, m_stb = 0, m_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_addr_gen i_refresh_addr_gen (
    .clk(clk), .rst(rst), .fetch_done(fetch_done), .r_load(r_load), .r_wdata(r_wdata),
    .i_load(i_load), .i_wdata(i_wdata), .rfsh_strobe(rfsh_strobe), .rfsh_addr(rfsh_addr),
    .r_value(r_value), .i_value(i_value)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "counter", int'(r_value), m_r);
    check(tag, "page", int'(i_value), m_i);
    check(tag, "strobe", int'(rfsh_strobe), m_stb);
    check(tag, "address", int'(rfsh_addr), m_addr);
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit rs, input bit f, input bit rl, input int rd,
                      input bit il, input int id, input string tag);
    rst = rs; fetch_done = f; r_load = rl; r_wdata = rd[7:0];
    i_load = il; i_wdata = id[7:0];
    @(posedge clk);
    if (rs) begin
      m_r = 0; m_i = 0; m_stb = 0; m_addr = 0;
    end else begin
      m_stb  = f ? 1 : 0;
      m_addr = f ? (m_i * 256 + m_r) : 0;
      if (rl)     m_r = rd & 255;
      else if (f) m_r = (m_r & 128) | ((m_r + 1) & 127);
      if (il)     m_i = id & 255;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int lfsr;
    @(negedge clk);
    step(1, 1, 1, 8'hFF, 1, 8'hFF, "R1");
    step(1, 0, 0, 0, 0, 0, "R1");
    // R8: slot address uses values before the edge
    step(0, 1, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R10");
    // R7: page write leaves counter alone
    step(0, 0, 0, 0, 1, 8'hA5, "R7");
    step(0, 1, 0, 0, 0, 0, "R8");
    // R4: wrap with bit 7 clear
    step(0, 0, 1, 8'h7E, 0, 0, "R5");
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 0, "R4");
    // R3/R4: wrap with bit 7 set
    step(0, 0, 1, 8'hFE, 0, 0, "R5");
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 0, "R3");
    // R6: load beats fetch, slot still happens
    step(0, 1, 1, 8'h40, 1, 8'h3C, "R6");
    step(0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R9");
    // Mixed traffic
    lfsr = 32'h1ACE;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) & 1) != 0 ? 32'h1021 : 0);
      lfsr = lfsr & 32'hFFFF;
      step((k % 97) == 50, lfsr[0], lfsr[3] & lfsr[5], (lfsr >> 4) & 255,
           lfsr[7] & lfsr[2], (lfsr >> 8) & 255, "R5");
    end
    step(1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule